// File: doc/BRIEF.md
# Multi-Channel Timer Register Decoder

This block is the register front end of a small timer unit with two or three down-counting channels. A single byte-addressed bus port with separate read and write strobes reaches three kinds of register. One shared run-control word switches the channels on and off. An optional one-bit output-control word can also be built in. Each channel has a window of three words in which software sets its reload value, reads or loads its live count, and controls its interrupt.

Each channel counts down by one on every PRESCALE-th clock while its run bit is set. When the count is zero at such a tick, the channel reloads from its reload word and latches an underflow flag. Every channel drives its own registered interrupt line. A build parameter chooses between two and three channels. A second parameter chooses whether the output-control word exists. Accesses to registers that are not built return zero and raise a one-cycle error pulse.

Top module: `tmr_unit_regs`

## Requirements
- R1: After a synchronous reset, the run-control word is 0, the output-control bit is 0, every reload and count word is all ones, every control word is 0, and bus_rdata, bus_err and irq_o are all 0.
- R2: The address is decoded with bus_addr[1:0] ignored. 0x04 is the run-control word. The channel windows start at 0x08, 0x14 and 0x20, and each holds reload (+0), count (+4) and control (+8). Read data appears on bus_rdata in the cycle after bus_re and is 0 in any cycle that follows no read.
- R3: Bit i of the run-control word runs channel i. The word reads back the last 3 bits written to it.
- R4: While a channel runs, every PRESCALE-th cycle is a tick. At a tick the count decrements, or, when it is 0, reloads from the reload word and sets the underflow flag.
- R5: Clearing a run bit freezes that channel's count. Setting it again resumes from the frozen count, and the prescale phase restarts from zero.
- R6: Control word bit 0 is the interrupt enable and bit 1 is the underflow flag. Writing 0 to bit 1 clears the flag, and writing 1 leaves it unchanged. An underflow in the same cycle wins. irq_o[i] is the registered AND of channel i's flag and enable, one line per channel.
- R7: With HAS_OCR=1, offset 0x00 stores only bit 0 of the write data and reads it back. With HAS_OCR=0, offset 0x00 is unmapped.
- R8: With NUM_CH=2, offsets 0x20 to 0x2B are unmapped. A write of run-control bit 2 raises the error pulse, while bits 0 and 1 still take effect.
- R9: An access to an unmapped offset (0x2C to 0x3F, or an absent register) has no effect on any register. A read of such an offset returns 0, and bus_err is high for exactly the cycle after the access.
- R10: A bus write to a count word loads that value, and it takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_re | input | 1 | Read strobe, one cycle per access |
| bus_we | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| bus_err | output | 1 | One-cycle pulse after an access to an unmapped offset or a bad run-control write |
| irq_o | output | NUM_CH | Per-channel interrupt lines |

## Verification
The bench drives the same bus sequence into two builds at once. The first has three channels, the output-control word and a prescale of 3. The second has two channels, no output-control word and a prescale of 2. The smaller build makes the absent-register paths reachable: the missing third window, the missing word at 0x00 and the flagged start bit 2. The two prescale values exercise both an odd and an even tick period against the same cycle-accurate model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int OCR_OFF    = 0;
  localparam int START_OFF  = 4;
  localparam int WIN0_BASE  = 8;
  localparam int WIN_BYTES  = 12;
  localparam int MAP_BYTES  = 48;
  localparam int MAX_CH     = 3;

  typedef enum logic [1:0] {
    W_RELOAD = 2'd0,
    W_COUNT  = 2'd1,
    W_CTRL   = 2'd2,
    W_NONE   = 2'd3
  } win_word_e;
endpackage

// File: rtl/tmr_addr_dec.sv
module tmr_addr_dec
  import tmr_pkg::*;
#(
  parameter int NUM_CH  = 3,
  parameter bit HAS_OCR = 1'b1,
  parameter int ADDR_W  = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              sel_ocr,
  output logic              sel_start,
  output logic [NUM_CH-1:0] sel_ch,
  output win_word_e         word,
  output logic              hit
);
  logic [ADDR_W-1:0] wa;
  assign wa = {addr[ADDR_W-1:2], 2'b00};

  always_comb begin
    sel_ch = '0;
    word   = W_NONE;
    for (int i = 0; i < NUM_CH; i++) begin
      if (int'(wa) >= WIN0_BASE + i*WIN_BYTES &&
          int'(wa) <  WIN0_BASE + (i+1)*WIN_BYTES) begin
        sel_ch[i] = 1'b1;
        word      = win_word_e'(2'((int'(wa) - WIN0_BASE - i*WIN_BYTES) / 4));
      end
    end
  end

  assign sel_ocr   = HAS_OCR && (wa == ADDR_W'(OCR_OFF));
  assign sel_start = (wa == ADDR_W'(START_OFF));
  assign hit       = sel_ocr | sel_start | (|sel_ch);
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int PRESCALE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic              we_i,
  input  win_word_e         word_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] reload_o,
  output logic [DATA_W-1:0] count_o,
  output logic              ie_o,
  output logic              flag_o,
  output logic              irq_o
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [PRE_W-1:0]  pre_q;
  logic [DATA_W-1:0] reload_q, count_q;
  logic              ie_q, flag_q, irq_q;
  logic              tick, uf;

  assign tick = run_i && (pre_q == PRE_W'(PRESCALE - 1));
  assign uf   = tick && (count_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q    <= '0;
      reload_q <= '1;
      count_q  <= '1;
      ie_q     <= 1'b0;
      flag_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (!run_i || tick) pre_q <= '0;
      else                pre_q <= pre_q + 1'b1;

      if (tick) count_q <= uf ? reload_q : count_q - 1'b1;
      if (we_i && word_i == W_COUNT)  count_q  <= wdata_i;
      if (we_i && word_i == W_RELOAD) reload_q <= wdata_i;
      if (we_i && word_i == W_CTRL)   ie_q     <= wdata_i[0];

      if (uf)                              flag_q <= 1'b1;
      else if (we_i && word_i == W_CTRL)   flag_q <= flag_q & wdata_i[1];

      irq_q <= flag_q & ie_q;
    end
  end

  assign reload_o = reload_q;
  assign count_o  = count_q;
  assign ie_o     = ie_q;
  assign flag_o   = flag_q;
  assign irq_o    = irq_q;

  assert_stop_holds_count_R5: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !(we_i && word_i == W_COUNT)) |=> $stable(count_q));

  assert_flag_needs_run_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(run_i));

  assert_count_load_R10: assert property (@(posedge clk) disable iff (rst)
    (we_i && word_i == W_COUNT) |=> (count_q == $past(wdata_i)));
endmodule

// File: rtl/tmr_unit_regs.sv
module tmr_unit_regs
  import tmr_pkg::*;
#(
  parameter int NUM_CH   = 3,
  parameter bit HAS_OCR  = 1'b1,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 6,
  parameter int PRESCALE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_re,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  output logic [NUM_CH-1:0] irq_o
);
  localparam int START_W = MAX_CH;
  localparam logic [START_W-1:0] CH_MASK = START_W'((1 << NUM_CH) - 1);

  logic              sel_ocr, sel_start, dec_hit;
  logic [NUM_CH-1:0] sel_ch;
  win_word_e         word;

  logic [START_W-1:0] start_q;
  logic               ocr_q;
  logic [DATA_W-1:0]  rdata_q, rd_mux;
  logic               err_q, bad;

  logic [DATA_W-1:0] ch_reload [NUM_CH];
  logic [DATA_W-1:0] ch_count  [NUM_CH];
  logic              ch_ie     [NUM_CH];
  logic              ch_flag   [NUM_CH];

  tmr_addr_dec #(.NUM_CH(NUM_CH), .HAS_OCR(HAS_OCR), .ADDR_W(ADDR_W)) u_dec (
    .addr      (bus_addr),
    .sel_ocr   (sel_ocr),
    .sel_start (sel_start),
    .sel_ch    (sel_ch),
    .word      (word),
    .hit       (dec_hit)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    tmr_chan #(.DATA_W(DATA_W), .PRESCALE(PRESCALE)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .run_i    (start_q[i]),
      .we_i     (bus_we && sel_ch[i]),
      .word_i   (word),
      .wdata_i  (bus_wdata),
      .reload_o (ch_reload[i]),
      .count_o  (ch_count[i]),
      .ie_o     (ch_ie[i]),
      .flag_o   (ch_flag[i]),
      .irq_o    (irq_o[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (sel_ocr)   rd_mux = DATA_W'(ocr_q);
    if (sel_start) rd_mux = DATA_W'(start_q);
    for (int i = 0; i < NUM_CH; i++) begin
      if (sel_ch[i]) begin
        case (word)
          W_RELOAD: rd_mux = ch_reload[i];
          W_COUNT:  rd_mux = ch_count[i];
          W_CTRL:   rd_mux = DATA_W'({ch_flag[i], ch_ie[i]});
          default:  rd_mux = '0;
        endcase
      end
    end
  end

  assign bad = ((bus_re || bus_we) && !dec_hit) ||
               (bus_we && sel_start && |(bus_wdata[START_W-1:0] & ~CH_MASK));

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      ocr_q   <= 1'b0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (bus_we && sel_start) start_q <= bus_wdata[START_W-1:0];
      if (bus_we && sel_ocr)   ocr_q   <= bus_wdata[0];
      rdata_q <= bus_re ? rd_mux : '0;
      err_q   <= bad;
    end
  end

  assign bus_rdata = rdata_q;
  assign bus_err   = err_q;

  assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sel_ocr, sel_start, sel_ch}));

  assert_idle_no_err_R9: assert property (@(posedge clk) disable iff (rst)
    !(bus_re || bus_we) |=> !bus_err);

  assert_miss_reads_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_re && !dec_hit) |=> (bus_rdata == '0 && bus_err));

  assert_no_rdata_without_read_R2: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> (bus_rdata == '0));
endmodule

// File: tb/test_tmr_unit_regs.sv
module test_tmr_unit_regs;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic        clk = 1'b0, rst = 1'b1, re = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_a, rdata_b;
  logic        err_a, err_b;
  logic [2:0]  irq_a;
  logic [1:0]  irq_b;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_unit_regs #(.NUM_CH(3), .HAS_OCR(1'b1), .DATA_W(32), .ADDR_W(6), .PRESCALE(3)) i_tmr_unit_regs (
    .clk(clk), .rst(rst), .bus_re(re), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata_a), .bus_err(err_a), .irq_o(irq_a));

  tmr_unit_regs #(.NUM_CH(2), .HAS_OCR(1'b0), .DATA_W(32), .ADDR_W(6), .PRESCALE(2)) i_tmr_unit_regs_two (
    .clk(clk), .rst(rst), .bus_re(re), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata_b), .bus_err(err_b), .irq_o(irq_b));

  // behavioural model, one slot per build
  int          nch [2]  = '{3, 2};
  bit          hocr [2] = '{1'b1, 1'b0};
  int          psc [2]  = '{3, 2};
  logic [31:0] m_rel [2][3];
  logic [31:0] m_cnt [2][3];
  bit          m_ie  [2][3];
  bit          m_flg [2][3];
  int          m_pre [2][3];
  logic [2:0]  m_start [2];
  bit          m_ocr [2];
  logic [31:0] e_rd [2];
  bit          e_err [2];
  logic [2:0]  e_irq [2];

  int    checks = 0, errors = 0, cycles = 0;
  bit    started = 0, done = 0;
  string cur_req = "R1";

  function automatic logic [32:0] lookup(int u, logic [5:0] a);
    int w;
    int c;
    int k;
    w = int'(a[5:2]);
    if (w == 0 && hocr[u]) return {1'b1, 31'b0, m_ocr[u]};
    if (w == 1)            return {1'b1, 29'b0, m_start[u]};
    if (w >= 2 && w < 2 + 3*nch[u]) begin
      c = (w - 2) / 3;
      k = (w - 2) % 3;
      if (k == 0) return {1'b1, m_rel[u][c]};
      if (k == 1) return {1'b1, m_cnt[u][c]};
      return {1'b1, 30'b0, m_flg[u][c], m_ie[u][c]};
    end
    return 33'b0;
  endfunction

  always @(posedge clk) begin
    cycles++;
    for (int u = 0; u < 2; u++) begin
      if (rst) begin
        m_start[u] = '0; m_ocr[u] = 0;
        e_rd[u] = '0; e_err[u] = 0; e_irq[u] = '0;
        for (int c = 0; c < 3; c++) begin
          m_rel[u][c] = '1; m_cnt[u][c] = '1; m_ie[u][c] = 0;
          m_flg[u][c] = 0;  m_pre[u][c] = 0;
        end
      end else begin
        logic [32:0] lk;
        logic [2:0]  st_old;
        int          w;
        bit          tick, uf;
        lk = lookup(u, addr);
        w  = int'(addr[5:2]);
        e_rd[u]  = re ? lk[31:0] : 32'b0;
        e_err[u] = ((re || we) && !lk[32]) || (we && w == 1 && nch[u] == 2 && wdata[2]);
        st_old = m_start[u];
        for (int c = 0; c < nch[u]; c++) begin
          e_irq[u][c] = m_flg[u][c] & m_ie[u][c];
          tick = st_old[c] && (m_pre[u][c] == psc[u] - 1);
          uf   = tick && (m_cnt[u][c] == 0);
          m_pre[u][c] = (!st_old[c] || tick) ? 0 : m_pre[u][c] + 1;
          if (tick) m_cnt[u][c] = uf ? m_rel[u][c] : m_cnt[u][c] - 1;
          if (we && lk[32] && w >= 2 && (w - 2) / 3 == c) begin
            case ((w - 2) % 3)
              0: m_rel[u][c] = wdata;
              1: m_cnt[u][c] = wdata;
              default: begin
                m_ie[u][c]  = wdata[0];
                m_flg[u][c] = m_flg[u][c] & wdata[1];
              end
            endcase
          end
          if (uf) m_flg[u][c] = 1;
        end
        if (we && w == 1) m_start[u] = wdata[2:0];
        if (we && w == 0 && hocr[u]) m_ocr[u] = wdata[0];
      end
    end
    started = 1;
    if (cycles > WATCHDOG && !done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected < %0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual %h expected %h", cur_req, what, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk("rdata(3ch)", rdata_a, e_rd[0]);
      chk("err(3ch)", 32'(err_a), 32'(e_err[0]));
      chk("irq(3ch)", 32'(irq_a), 32'(e_irq[0]));
      chk("rdata(2ch)", rdata_b, e_rd[1]);
      chk("err(2ch)", 32'(err_b), 32'(e_err[1]));
      chk("irq(2ch)", 32'(irq_b), 32'(e_irq[1][1:0]));
    end
  end

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [5:0] a);
    @(negedge clk); re = 1'b1; addr = a;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cur_req = "R1";
    idle(3); rst = 1'b0;
    rd(6'h08); rd(6'h0C); rd(6'h10); rd(6'h04); rd(6'h00);

    cur_req = "R7";
    wr(6'h00, 32'hFFFF_FFFE); rd(6'h00);
    wr(6'h00, 32'h0000_0003); rd(6'h02);

    cur_req = "R2";
    for (int c = 0; c < 3; c++) begin
      wr(6'(8 + 12*c), 32'(6 + c));
      wr(6'(12 + 12*c), 32'(2 + c));
      wr(6'(16 + 12*c), 32'h1);
      rd(6'(8 + 12*c)); rd(6'(12 + 12*c)); rd(6'(16 + 12*c));
    end

    cur_req = "R3";
    wr(6'h04, 32'h7); rd(6'h04);

    cur_req = "R4";
    for (int k = 0; k < 8; k++) begin
      rd(6'h0C); rd(6'h18); rd(6'h24); idle(1);
    end

    cur_req = "R6";
    rd(6'h10);
    wr(6'h10, 32'h3); rd(6'h10);
    wr(6'h10, 32'h1); rd(6'h10);
    wr(6'h1C, 32'h0); idle(15); rd(6'h1C);

    cur_req = "R5";
    wr(6'h04, 32'h0); rd(6'h0C); idle(9); rd(6'h0C); rd(6'h18);
    wr(6'h04, 32'h3); idle(1); rd(6'h0C); idle(4); rd(6'h0C);

    cur_req = "R10";
    wr(6'h0C, 32'h0); rd(6'h0C);
    wr(6'h18, 32'd100); rd(6'h18); idle(6); rd(6'h18);

    cur_req = "R8";
    wr(6'h04, 32'h4); rd(6'h04);
    rd(6'h20); rd(6'h24); wr(6'h28, 32'h3); rd(6'h28);
    wr(6'h04, 32'h6); idle(8); rd(6'h24); rd(6'h18);

    cur_req = "R9";
    rd(6'h2C); rd(6'h30); rd(6'h3C);
    wr(6'h34, 32'h5); wr(6'h2E, 32'h9);
    rd(6'h0B); rd(6'h04);
    @(negedge clk); re = 1'b1; addr = 6'h31;
    @(negedge clk); addr = 6'h3F;
    @(negedge clk); re = 1'b0;
    idle(3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule